// File: doc/BRIEF.md
# Floppy Controller Glue Port

This block sits between a CPU's 8-bit I/O bus and an external floppy disk controller. It presents two byte-wide ports. The control port latches which drive is selected, the motor-on line, the terminal-count line and an interrupt enable. A read of the control port returns a status byte that carries the controller's live DMA request and index pulse and the latched motor state.

The data port does no processing. A CPU write to it becomes a single-cycle DMA-style write strobe to the controller, with the CPU data passed through unchanged. A CPU read from it becomes a DMA-style read strobe, and the controller's data is returned to the CPU in the same cycle.

The controller's interrupt reaches the CPU only while the interrupt enable bit is set. The disk controller itself is outside this block.

Top module: `fdc_glue_port`

## Requirements
- R1: After reset, the drive number is 0, and motor-on, terminal-count and interrupt enable are all 0.
- R2: A write to the control port (address 0xF8) with any of data bits 0..2 set loads the drive number with the position of the lowest set bit among them. The new value shows on `drive_sel` on the cycle after the write.
- R3: A control-port write with data bits 0..2 all clear leaves the drive number unchanged.
- R4: Data bit 4 of a control-port write is latched and drives `motor_on`.
- R5: Data bit 5 of a control-port write is latched and drives `term_count`.
- R6: Data bit 7 of a control-port write is latched as the interrupt enable. `cpu_irq` is the level AND of `fdc_int` and that enable, with no register between them.
- R7: While a control-port read is active, `io_rdata` shows 0xF8 with `fdc_drq` in bit 0, `fdc_index` in bit 1 and the latched motor state in bit 2. The drq and index bits follow the live inputs in the same cycle.
- R8: A write to the data port (address 0xF9) raises `fdc_dma_wr` for that cycle, with `fdc_dma_wdata` equal to `io_wdata`. `fdc_dma_wr` stays low for writes to any other address.
- R9: A read of the data port raises `fdc_dma_rd` for that cycle, and `io_rdata` equals `fdc_dma_rdata`. `fdc_dma_rd` stays low for reads of any other address.
- R10: Writes to addresses other than 0xF8 change none of the latched control state.
- R11: `io_rdata` is 0x00 whenever no read of 0xF8 or 0xF9 is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 8 | Low byte of the I/O address |
| io_wr | input | 1 | I/O write strobe, one cycle |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | CPU write data |
| io_rdata | output | 8 | CPU read data |
| fdc_drq | input | 1 | Controller DMA request |
| fdc_index | input | 1 | Index pulse from the drive |
| fdc_int | input | 1 | Controller interrupt |
| fdc_dma_rdata | input | 8 | Data from the controller's DMA channel |
| drive_sel | output | 2 | Selected drive number |
| motor_on | output | 1 | Motor-on line |
| term_count | output | 1 | Terminal-count line |
| fdc_dma_wr | output | 1 | DMA write strobe to the controller |
| fdc_dma_rd | output | 1 | DMA read strobe to the controller |
| fdc_dma_wdata | output | 8 | Data to the controller's DMA channel |
| cpu_irq | output | 1 | Gated interrupt request to the CPU |

## Verification
Every one of the 256 control bytes is written in turn, and the expected drive number is carried forward from the previous write. This separates lowest-bit priority from highest-bit priority, and it separates "hold on empty select" from "clear on empty select". After each write, the status byte is read under all four drq/index combinations, and `fdc_int` is toggled. This ties each status bit and the interrupt gate to its own source. Writes of 0xFF to all 254 other addresses show whether the address decode is too loose. Sweeps of all 256 data bytes through the data port in both directions catch dropped or swapped data bits and strobes that fire on the wrong access.

// File: rtl/fdc_glue_pkg.sv
package fdc_glue_pkg;
  // Control-port bit positions (the external controller depends on them)
  localparam int unsigned MOTOR_BIT = 4;
  localparam int unsigned TC_BIT    = 5;
  localparam int unsigned IE_BIT    = 7;
  // Fixed upper pattern of the status byte
  localparam logic [7:0] STATUS_FILL = 8'hF8;

  typedef struct packed {
    logic ie;
    logic tc;
    logic motor;
  } ctl_flags_t;
endpackage

// File: rtl/fdc_glue_decode.sv
module fdc_glue_decode #(
  parameter logic [7:0] CTRL_ADDR = 8'hF8,
  parameter logic [7:0] DATA_ADDR = 8'hF9
) (
  input  logic [7:0] io_addr,
  input  logic       io_wr,
  input  logic       io_rd,
  output logic       wr_ctrl,
  output logic       rd_ctrl,
  output logic       wr_data,
  output logic       rd_data
);
  logic hit_ctrl;
  logic hit_data;

  always_comb begin
    hit_ctrl = (io_addr == CTRL_ADDR);
    hit_data = (io_addr == DATA_ADDR);
    wr_ctrl  = io_wr & hit_ctrl;
    rd_ctrl  = io_rd & hit_ctrl;
    wr_data  = io_wr & hit_data;
    rd_data  = io_rd & hit_data;
  end
endmodule

// File: rtl/fdc_glue_ctrl.sv
module fdc_glue_ctrl
  import fdc_glue_pkg::*;
#(
  parameter int unsigned DRV_COUNT = 3,
  parameter int unsigned DSEL_W    = (DRV_COUNT > 1) ? $clog2(DRV_COUNT) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [DRV_COUNT-1:0] sel_bits,
  input  ctl_flags_t           flags_in,
  output logic [DSEL_W-1:0]    drv_q,
  output ctl_flags_t           flags_q
);
  // Lowest-bit priority chain
  logic [DRV_COUNT:0]   seen;
  logic [DRV_COUNT-1:0] first;
  assign seen[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < DRV_COUNT; g++) begin : g_prio
      assign first[g]  = sel_bits[g] & ~seen[g];
      assign seen[g+1] = seen[g] | sel_bits[g];
    end
  endgenerate

  logic [DSEL_W-1:0] enc_idx;
  logic [DSEL_W-1:0] drv_d;
  ctl_flags_t        flags_d;

  always_comb begin
    enc_idx = '0;
    for (int i = 0; i < DRV_COUNT; i++) begin
      if (first[i]) enc_idx = enc_idx | DSEL_W'(i);
    end
  end

  // Next state
  always_comb begin
    drv_d   = drv_q;
    flags_d = flags_q;
    if (wr_en) begin
      flags_d = flags_in;
      if (seen[DRV_COUNT]) drv_d = enc_idx;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q   <= '0;
      flags_q <= '0;
    end else if (wr_en) begin
      drv_q   <= drv_d;
      flags_q <= flags_d;
    end
  end

  AST_DSEL_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_bits[0]) |=> (drv_q == '0)); // R2
  AST_DSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (sel_bits == '0)) |=> $stable(drv_q)); // R3
  AST_MOTOR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (flags_q.motor == $past(flags_in.motor))); // R4
  AST_TC_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (flags_q.tc == $past(flags_in.tc))); // R5
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(drv_q) && $stable(flags_q))); // R10
endmodule

// File: rtl/fdc_glue_status.sv
module fdc_glue_status
  import fdc_glue_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_ctrl,
  input  logic       rd_data,
  input  logic       drq,
  input  logic       index_in,
  input  logic       motor,
  input  logic [7:0] dma_rdata,
  output logic [7:0] rdata
);
  logic [7:0] status_byte;

  always_comb begin
    status_byte = STATUS_FILL | {5'b0, motor, index_in, drq};
    rdata       = 8'h00;
    if (rd_ctrl)      rdata = status_byte;
    else if (rd_data) rdata = dma_rdata;
  end

  AST_STATUS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl |-> (rdata[7:3] == 5'b11111)); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_ctrl && !rd_data) |-> (rdata == 8'h00)); // R11
endmodule

// File: rtl/fdc_glue_port.sv
module fdc_glue_port
  import fdc_glue_pkg::*;
#(
  parameter logic [7:0]  CTRL_ADDR = 8'hF8,
  parameter logic [7:0]  DATA_ADDR = 8'hF9,
  parameter int unsigned DRV_COUNT = 3,
  parameter int unsigned DSEL_W    = (DRV_COUNT > 1) ? $clog2(DRV_COUNT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              fdc_drq,
  input  logic              fdc_index,
  input  logic              fdc_int,
  input  logic [7:0]        fdc_dma_rdata,
  output logic [DSEL_W-1:0] drive_sel,
  output logic              motor_on,
  output logic              term_count,
  output logic              fdc_dma_wr,
  output logic              fdc_dma_rd,
  output logic [7:0]        fdc_dma_wdata,
  output logic              cpu_irq
);
  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic wr_ctrl, rd_ctrl, wr_data, rd_data;

  fdc_glue_decode #(
    .CTRL_ADDR(CTRL_ADDR),
    .DATA_ADDR(DATA_ADDR)
  ) i_decode (
    .io_addr (io_addr),
    .io_wr   (io_wr),
    .io_rd   (io_rd),
    .wr_ctrl (wr_ctrl),
    .rd_ctrl (rd_ctrl),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );

  ctl_flags_t flags_in, flags_q;

  always_comb begin
    flags_in.motor = io_wdata[MOTOR_BIT];
    flags_in.tc    = io_wdata[TC_BIT];
    flags_in.ie    = io_wdata[IE_BIT];
  end

  fdc_glue_ctrl #(
    .DRV_COUNT(DRV_COUNT),
    .DSEL_W   (DSEL_W)
  ) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_ctrl),
    .sel_bits (io_wdata[DRV_COUNT-1:0]),
    .flags_in (flags_in),
    .drv_q    (drive_sel),
    .flags_q  (flags_q)
  );

  fdc_glue_status i_status (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rd_ctrl   (rd_ctrl),
    .rd_data   (rd_data),
    .drq       (fdc_drq),
    .index_in  (fdc_index),
    .motor     (flags_q.motor),
    .dma_rdata (fdc_dma_rdata),
    .rdata     (io_rdata)
  );

  assign motor_on      = flags_q.motor;
  assign term_count    = flags_q.tc;
  assign fdc_dma_wr    = wr_data;
  assign fdc_dma_rd    = rd_data;
  assign fdc_dma_wdata = io_wdata;
  assign cpu_irq       = fdc_int & flags_q.ie;

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    !flags_q.ie |-> !cpu_irq); // R6
  AST_DMA_WR_ADDR: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    fdc_dma_wr |-> (io_wr && io_addr == DATA_ADDR)); // R8
  AST_DMA_RD_ADDR: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    fdc_dma_rd |-> (io_rd && io_addr == DATA_ADDR)); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> (drive_sel == '0 && !motor_on && !term_count && !cpu_irq)); // R1
endmodule

// File: tb/test_fdc_glue_port.sv
module test_fdc_glue_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] io_addr = 8'h00;
  logic       io_wr = 1'b0;
  logic       io_rd = 1'b0;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata;
  logic       fdc_drq = 1'b0;
  logic       fdc_index = 1'b0;
  logic       fdc_int = 1'b0;
  logic [7:0] fdc_dma_rdata = 8'h00;
  logic [1:0] drive_sel;
  logic       motor_on, term_count, fdc_dma_wr, fdc_dma_rd, cpu_irq;
  logic [7:0] fdc_dma_wdata;

  int n_cmp = 0;
  int n_bad = 0;
  logic       done = 1'b0;

  // expected model
  logic [1:0] e_drv;
  logic       e_mot, e_tc, e_ie;

  always #4 clk = ~clk; // 125 MHz

  fdc_glue_port i_fdc_glue_port (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .fdc_drq(fdc_drq),
    .fdc_index(fdc_index), .fdc_int(fdc_int), .fdc_dma_rdata(fdc_dma_rdata),
    .drive_sel(drive_sel), .motor_on(motor_on), .term_count(term_count),
    .fdc_dma_wr(fdc_dma_wr), .fdc_dma_rd(fdc_dma_rd),
    .fdc_dma_wdata(fdc_dma_wdata), .cpu_irq(cpu_irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    #1;
    chk("R8 dma_wr", {7'b0, fdc_dma_wr}, {7'b0, (a == 8'hF9)});
    if (a == 8'hF9) chk("R8 dma_wdata", fdc_dma_wdata, d);
    @(negedge clk);
    io_wr = 1'b0;
    #1;
  endtask

  task automatic check_state(input string req);
    chk({req, " drive"}, {6'b0, drive_sel}, {6'b0, e_drv});
    chk({req, " motor R4"}, {7'b0, motor_on}, {7'b0, e_mot});
    chk({req, " tc R5"}, {7'b0, term_count}, {7'b0, e_tc});
  endtask

  initial begin
    #1500000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    e_drv = 2'd0; e_mot = 1'b0; e_tc = 1'b0; e_ie = 1'b0;
    check_state("R1");
    fdc_int = 1'b1; #1;
    chk("R1 irq", {7'b0, cpu_irq}, 8'h00);
    fdc_int = 1'b0;
    chk("R11 idle rdata", io_rdata, 8'h00);

    // Exhaustive control-byte sweep
    for (int v = 0; v < 256; v++) begin
      logic [7:0] d;
      d = 8'(v);
      io_write(8'hF8, d);
      if (d[0])      e_drv = 2'd0;  // R2
      else if (d[1]) e_drv = 2'd1;
      else if (d[2]) e_drv = 2'd2;
      // else R3 hold
      e_mot = d[4]; e_tc = d[5]; e_ie = d[7];
      check_state((d[2:0] == 3'b000) ? "R3" : "R2");
      for (int s = 0; s < 4; s++) begin
        fdc_drq = s[0]; fdc_index = s[1];
        io_addr = 8'hF8; io_rd = 1'b1; #1;
        chk("R7 status", io_rdata, 8'hF8 | {5'b0, e_mot, s[1], s[0]});
        chk("R9 no dma_rd", {7'b0, fdc_dma_rd}, 8'h00);
        io_rd = 1'b0; #1;
        chk("R11 rdata idle", io_rdata, 8'h00);
      end
      fdc_int = 1'b1; #1;
      chk("R6 irq high", {7'b0, cpu_irq}, {7'b0, e_ie});
      fdc_int = 1'b0; #1;
      chk("R6 irq low", {7'b0, cpu_irq}, 8'h00);
    end

    // R10 other addresses: set known state then blast 0xFF
    io_write(8'hF8, 8'h02);
    e_drv = 2'd1; e_mot = 1'b0; e_tc = 1'b0; e_ie = 1'b0;
    for (int a = 0; a < 256; a++) begin
      if (a != 8'hF8 && a != 8'hF9) begin
        io_write(8'(a), 8'hFF);
        check_state("R10");
        fdc_int = 1'b1; #1;
        chk("R10 ie", {7'b0, cpu_irq}, 8'h00);
        fdc_int = 1'b0;
        io_rd = 1'b1; #1;
        chk("R11 other read", io_rdata, 8'h00);
        io_rd = 1'b0; #1;
      end
    end

    // R8 / R9 data port sweep
    for (int v = 0; v < 256; v++) begin
      io_write(8'hF9, 8'(v));
      check_state("R8 no ctrl change");
      @(negedge clk);
      io_addr = 8'hF9; fdc_dma_rdata = 8'(255 - v); io_rd = 1'b1; #1;
      chk("R9 rdata", io_rdata, 8'(255 - v));
      chk("R9 dma_rd", {7'b0, fdc_dma_rd}, 8'h01);
      io_rd = 1'b0; #1;
      chk("R9 dma_rd low", {7'b0, fdc_dma_rd}, 8'h00);
    end

    // R1 again: reset mid-run clears everything
    io_write(8'hF8, 8'hB4);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); #1;
    e_drv = 2'd0; e_mot = 1'b0; e_tc = 1'b0; e_ie = 1'b0;
    check_state("R1 rerset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check_state("R1 after release");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule